// File: doc/BRIEF.md
# Half-Precision Lane Compare Unit

This block compares two IEEE 754 binary16 values for one SIMD lane. It returns the result as a 16-bit lane mask: all ones when the selected relation holds and all zeros when it does not. A 5-bit opcode selects one of five relations:

- equality;
- greater-or-equal;
- greater-than;
- greater-or-equal on magnitudes;
- greater-than on magnitudes.

With each result the block also reports an invalid-operation exception and an illegal-opcode indication. A vector datapath places one instance per lane. The unit accepts a new operand pair on any cycle that `in_valid` is high and presents the registered result exactly one cycle later.

The output side is a two-state machine. `ST_IDLE` means no result is held. `ST_EMIT` means a result is on the outputs. The state moves to `ST_EMIT` on every cycle with `in_valid` high, whether it starts from `ST_IDLE` or from `ST_EMIT`. It returns to `ST_IDLE` on every cycle with `in_valid` low. A synchronous reset forces `ST_IDLE`.

Top module: `hcmp_lane`

## Requirements
- R1: The opcode value selects the relation: 5'h04 is equal, 5'h14 is greater-or-equal, 5'h1C is greater-than, 5'h15 is magnitude greater-or-equal and 5'h1D is magnitude greater-than.
- R2: A true relation drives `mask` to 16'hFFFF and a false one to 16'h0000; while `out_valid` is high no other mask value appears.
- R3: The result and flags appear one cycle after a cycle with `in_valid` high, and `out_valid` is high in exactly that cycle. After a cycle with `in_valid` low, `out_valid`, `mask`, `inv_flag` and `bad_op` are all 0. Back-to-back inputs produce back-to-back results.
- R4: A synchronous active-high `rst` clears `out_valid`, `mask`, `inv_flag` and `bad_op` at the next clock edge, even when `in_valid` is high.
- R5: Equality is true only for two non-NaN operands of equal value; +0 (16'h0000) and -0 (16'h8000) are equal.
- R6: Greater-or-equal and greater-than order non-NaN values numerically. This holds for negative values, infinities and subnormals; subnormals are not flushed to zero.
- R7: The magnitude variants compare the operands with bit 15 (sign) cleared and otherwise follow R6.
- R8: An operand is a NaN when bits 14:10 are all ones and bits 9:0 are nonzero. If either operand is a NaN, every relation is false.
- R9: For equality, `inv_flag` is set only when an operand is a signalling NaN, that is, a NaN with bit 9 clear; a quiet NaN (bit 9 set) does not set it.
- R10: For the four ordered relations (plain and magnitude), `inv_flag` is set when either operand is any NaN.
- R11: Any other opcode sets `bad_op`, drives `mask` to 16'h0000 and keeps `inv_flag` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair and opcode present this cycle |
| opcode | input | 5 | Relation select |
| opa | input | 16 | First binary16 operand |
| opb | input | 16 | Second binary16 operand |
| out_valid | output | 1 | Registered result present |
| mask | output | 16 | All-ones or all-zeros lane mask |
| inv_flag | output | 1 | Invalid-operation exception |
| bad_op | output | 1 | Opcode is not one of the five relations |

## Verification
The assertions check the following on every cycle:
- the one-cycle link between `in_valid` and `out_valid`;
- the all-or-nothing shape of the mask;
- the forced-false mask when either operand of the previous cycle was a NaN;
- the clean result for an illegal opcode.

The bench's scenarios are needed for everything that depends on the numeric relation: the opcode-to-relation mapping, signed-zero equality, subnormal and negative ordering, the magnitude variants, and the quiet-versus-signalling NaN difference in the invalid flag. The bench also exercises reset overriding a valid input, and the zeroed outputs after an idle cycle.

// File: rtl/hcmp_pkg.sv
package hcmp_pkg;

    typedef enum logic [2:0] {
        CMP_NONE,
        CMP_EQ,
        CMP_GE,
        CMP_GT,
        CMP_AGE,
        CMP_AGT
    } cmp_kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_EMIT
    } out_state_e;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
    } fp_class_t;

    localparam logic [4:0] OPC_EQ  = 5'h04;
    localparam logic [4:0] OPC_GE  = 5'h14;
    localparam logic [4:0] OPC_GT  = 5'h1C;
    localparam logic [4:0] OPC_AGE = 5'h15;
    localparam logic [4:0] OPC_AGT = 5'h1D;

endpackage

// File: rtl/hcmp_classify.sv
module hcmp_classify
    import hcmp_pkg::*;
#(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10,
    localparam int W = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0] val,
    output fp_class_t    cls
);
    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] mant;

    always_comb begin
        expo        = val[W-2 -: EXP_W];
        mant        = val[MAN_W-1:0];
        cls.is_nan  = (&expo) && (|mant);
        // the top fraction bit marks a quiet NaN
        cls.is_snan = cls.is_nan && !mant[MAN_W-1];
    end
endmodule

// File: rtl/hcmp_decode.sv
module hcmp_decode
    import hcmp_pkg::*;
(
    input  logic [4:0] opcode,
    output cmp_kind_e  kind
);
    always_comb begin
        case (opcode)
            OPC_EQ:  kind = CMP_EQ;
            OPC_GE:  kind = CMP_GE;
            OPC_GT:  kind = CMP_GT;
            OPC_AGE: kind = CMP_AGE;
            OPC_AGT: kind = CMP_AGT;
            default: kind = CMP_NONE;
        endcase
    end
endmodule

// File: rtl/hcmp_relation.sv
module hcmp_relation
    import hcmp_pkg::*;
#(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10,
    localparam int W = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         mag_only,
    output logic         rel_eq,
    output logic         rel_gt,
    output logic         any_nan,
    output logic         any_snan
);
    logic [W-1:0] opnd [2];
    fp_class_t    cls  [2];

    assign opnd[0] = a;
    assign opnd[1] = b;

    for (genvar g = 0; g < 2; g++) begin : g_cls
        hcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .val (opnd[g]),
            .cls (cls[g])
        );
    end

    logic         sa, sb;
    logic [W-2:0] ma, mb;
    logic         ordered;

    always_comb begin
        ma       = a[W-2:0];
        mb       = b[W-2:0];
        sa       = a[W-1] && !mag_only;
        sb       = b[W-1] && !mag_only;
        any_nan  = cls[0].is_nan  || cls[1].is_nan;
        any_snan = cls[0].is_snan || cls[1].is_snan;
        ordered  = !any_nan;
        rel_eq   = ordered && (((ma == '0) && (mb == '0)) || ((sa == sb) && (ma == mb)));
        if (!ordered || rel_eq) begin
            rel_gt = 1'b0;
        end else if (sa != sb) begin
            rel_gt = !sa;
        end else if (sa) begin
            rel_gt = ma < mb;
        end else begin
            rel_gt = ma > mb;
        end
    end
endmodule

// File: rtl/hcmp_lane.sv
module hcmp_lane
    import hcmp_pkg::*;
#(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10,
    localparam int W = 1 + EXP_W + MAN_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [4:0]   opcode,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         out_valid,
    output logic [W-1:0] mask,
    output logic         inv_flag,
    output logic         bad_op
);
    cmp_kind_e  kind;
    out_state_e state, state_nx;
    logic       rel_eq, rel_gt, any_nan, any_snan;
    logic       mag_only, hit, inv_nx, bad_nx;

    hcmp_decode u_dec (
        .opcode (opcode),
        .kind   (kind)
    );

    assign mag_only = (kind == CMP_AGE) || (kind == CMP_AGT);

    hcmp_relation #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_rel (
        .a        (opa),
        .b        (opb),
        .mag_only (mag_only),
        .rel_eq   (rel_eq),
        .rel_gt   (rel_gt),
        .any_nan  (any_nan),
        .any_snan (any_snan)
    );

    always_comb begin
        hit    = 1'b0;
        inv_nx = 1'b0;
        bad_nx = 1'b0;
        unique case (kind)
            CMP_EQ: begin
                hit    = rel_eq;
                inv_nx = any_snan;
            end
            CMP_GE, CMP_AGE: begin
                hit    = rel_eq || rel_gt;
                inv_nx = any_nan;
            end
            CMP_GT, CMP_AGT: begin
                hit    = rel_gt;
                inv_nx = any_nan;
            end
            CMP_NONE: begin
                bad_nx = 1'b1;
            end
            default: begin
                bad_nx = 1'b1;
            end
        endcase
    end

    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_nx = in_valid ? ST_EMIT : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !in_valid) begin
            mask     <= '0;
            inv_flag <= 1'b0;
            bad_op   <= 1'b0;
        end else begin
            mask     <= {W{hit}};
            inv_flag <= inv_nx;
            bad_op   <= bad_nx;
        end
    end

    assign out_valid = (state == ST_EMIT);
endmodule

// File: rtl/hcmp_lane_chk.sv
module hcmp_lane_chk #(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10,
    localparam int W = 1 + EXP_W + MAN_W
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic         out_valid,
    input logic [W-1:0] mask,
    input logic         inv_flag,
    input logic         bad_op
);
    logic nan_in;
    assign nan_in = ((&opa[W-2 -: EXP_W]) && (|opa[MAN_W-1:0])) ||
                    ((&opb[W-2 -: EXP_W]) && (|opb[MAN_W-1:0]));

    // R3
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && mask == '0 && !inv_flag && !bad_op));

    // R2
    mask_shape_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (mask == '0 || mask == '1));

    // R8
    nan_false_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && nan_in) |=> (mask == '0));

    // R11
    bad_clean_chk: assert property (@(posedge clk) disable iff (rst)
        bad_op |-> (out_valid && mask == '0 && !inv_flag));
endmodule

bind hcmp_lane hcmp_lane_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .opa       (opa),
    .opb       (opb),
    .out_valid (out_valid),
    .mask      (mask),
    .inv_flag  (inv_flag),
    .bad_op    (bad_op)
);

// File: tb/hcmp_lane_test.sv
`timescale 1ns/1ps
module hcmp_lane_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [4:0]  opcode = '0;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic        out_valid;
    logic [15:0] mask;
    logic        inv_flag;
    logic        bad_op;
    int          checks = 0;
    int          errors = 0;
    logic        done = 1'b0;

    always #4 clk = ~clk;

    hcmp_lane uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .opcode    (opcode),
        .opa       (opa),
        .opb       (opb),
        .out_valid (out_valid),
        .mask      (mask),
        .inv_flag  (inv_flag),
        .bad_op    (bad_op)
    );

    // {opcode, a, b, expected true, expected invalid, expected illegal}
    localparam int NV = 30;
    localparam logic [39:0] VECS [NV] = '{
        {5'h04, 16'h3C00, 16'h3C00, 3'b100},  // R1 R5 equal
        {5'h04, 16'h3C00, 16'h4000, 3'b000},  // R5
        {5'h04, 16'h0000, 16'h8000, 3'b100},  // R5 signed zeros
        {5'h04, 16'h7C00, 16'h7C00, 3'b100},  // R5 infinities
        {5'h04, 16'h7E00, 16'h3C00, 3'b000},  // R9 quiet NaN, no flag
        {5'h04, 16'h7C01, 16'h3C00, 3'b010},  // R9 signalling NaN
        {5'h14, 16'h4000, 16'h3C00, 3'b100},  // R1 R6
        {5'h14, 16'h3C00, 16'h3C00, 3'b100},  // R6
        {5'h14, 16'hBC00, 16'hC000, 3'b100},  // R6 negatives
        {5'h14, 16'hC000, 16'hBC00, 3'b000},  // R6
        {5'h14, 16'h0002, 16'h0001, 3'b100},  // R6 subnormal
        {5'h14, 16'h8000, 16'h0000, 3'b100},  // R6 zeros
        {5'h14, 16'hC000, 16'h3C00, 3'b000},  // R6 signed
        {5'h14, 16'h7E00, 16'h3C00, 3'b010},  // R10 quiet NaN
        {5'h1C, 16'h3C00, 16'h3C00, 3'b000},  // R1 R6
        {5'h1C, 16'h4000, 16'h3C00, 3'b100},  // R6
        {5'h1C, 16'h8001, 16'h0001, 3'b000},  // R6 subnormal sign
        {5'h1C, 16'h0001, 16'h8001, 3'b100},  // R6
        {5'h1C, 16'hFC00, 16'hC000, 3'b000},  // R6 minus infinity
        {5'h1C, 16'h0001, 16'h0000, 3'b100},  // R6 no flush
        {5'h1C, 16'h3C00, 16'h7C01, 3'b010},  // R8 R10
        {5'h15, 16'hC000, 16'h3C00, 3'b100},  // R1 R7
        {5'h15, 16'hBC00, 16'h4000, 3'b000},  // R7
        {5'h15, 16'hBC00, 16'h3C00, 3'b100},  // R7
        {5'h1D, 16'hC000, 16'h4000, 3'b000},  // R1 R7
        {5'h1D, 16'hC000, 16'h3C00, 3'b100},  // R7
        {5'h1D, 16'hFE00, 16'h3C00, 3'b010},  // R7 R8 R10
        {5'h00, 16'h3C00, 16'h3C00, 3'b001},  // R11
        {5'h05, 16'h7C01, 16'h7C01, 3'b001},  // R11 no invalid
        {5'h1F, 16'h0000, 16'h0000, 3'b001}   // R11
    };

    task automatic check(input string req, input logic [18:0] act, input logic [18:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] op, input logic [15:0] a, input logic [15:0] b);
        opcode   = op;
        opa      = a;
        opb      = b;
        in_valid = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R4 reset state
        check("R4 reset", {out_valid, mask, inv_flag, bad_op}, 19'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i][39:35], VECS[i][34:19], VECS[i][18:3]);
            @(negedge clk);
            in_valid = 1'b0;
            check($sformatf("vector %0d (R1/R2)", i),
                  {out_valid, mask, inv_flag, bad_op},
                  {1'b1, {16{VECS[i][2]}}, VECS[i][1], VECS[i][0]});
        end

        // R3 idle cycle zeroes outputs
        @(negedge clk);
        check("R3 idle", {out_valid, mask, inv_flag, bad_op}, 19'h0);

        // R3 back-to-back
        @(negedge clk);
        drive(5'h04, 16'h3C00, 16'h3C00);
        @(negedge clk);
        check("R3 stream first", {out_valid, mask, inv_flag, bad_op}, {1'b1, 16'hFFFF, 2'b00});
        drive(5'h14, 16'h7C01, 16'h3C00);
        @(negedge clk);
        check("R3 stream second", {out_valid, mask, inv_flag, bad_op}, {1'b1, 16'h0000, 2'b10});
        drive(5'h0A, 16'h0000, 16'h0000);
        @(negedge clk);
        in_valid = 1'b0;
        check("R3 stream third", {out_valid, mask, inv_flag, bad_op}, {1'b1, 16'h0000, 2'b01});

        // R4 reset overrides valid input
        @(negedge clk);
        drive(5'h04, 16'h3C00, 16'h3C00);
        rst = 1'b1;
        @(negedge clk);
        check("R4 reset with valid", {out_valid, mask, inv_flag, bad_op}, 19'h0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule